// File: doc/BRIEF.md
# Paged Chip-Select Decoder

This block turns each bus access of an 8-bit controller with a 16-bit address into one chip select. The controller has a code-fetch strobe and separate data read and data write strobes. The targets are eight sectors of a 256 KB main flash, four 8 KB boot-flash sectors, an SRAM and a small I/O register block.

The main flash is seen through a 32 KB window in the upper half of the address space. A page register picks which sector appears there. A mapping register decides whether each flash memory answers code fetches, data accesses or both. Both registers sit inside the I/O block. When regions overlap, a fixed priority decides which select wins.

All outputs are registered, so each select is valid in the cycle after the strobe. Data writes that land on flash never raise the memory write strobe. Instead they set a sticky flag that software can clear later.

Top module: `pwd_decoder`

## Requirements
- R1: After reset all selects, `mem_we`, `reg_rdata` and `flash_wr_flag` are 0, and both the page register and the mapping register read back as 0. In that state boot flash answers code fetches only, and main flash is off in both spaces.
- R2: Outputs are registered. The selects, `mem_we` and `reg_rdata` reflect the access presented in the previous cycle. A cycle with no strobe yields no select.
- R3: With mapping bit 0 set, a code fetch in 0x8000–0xFFFF asserts only `fs_sel[page]`. The page is the low 3 bits written at I/O offset 0x00 (address 0x0100).
- R4: With mapping bit 4 set, a data read or write in 0x8000–0xFFFF asserts `fs_sel[page]`. With bit 4 clear, the main flash answers no data access.
- R5: Boot sector k (k = addr[14:13]) answers code fetches in 0x0000–0x7FFF unless mapping bit 2 is set. Mapping bit 1 also places the boot flash in data space. Mapping bit 3 moves the boot flash to 0x8000–0xFFFF.
- R6: `sram_sel` covers data accesses in 0x0200–0x7FFF. `iop_sel` covers data accesses in 0x0100–0x01FF. Neither answers a code fetch.
- R7: Priority runs I/O over SRAM, SRAM over boot flash, and boot flash over main flash. At most one select is asserted, and the winner removes the overlapped range from every lower one.
- R8: With mapping bit 1 clear, data accesses to 0x0000–0x00FF assert no select.
- R9: `mem_we` is asserted only for a data write that selects the SRAM or the I/O block. It is never asserted together with a flash select.
- R10: A data write that selects any flash sector sets `flash_wr_flag`. The flag stays set until the mapping register (address 0x0101) is written with bit 7 at 1. Bit 7 is not stored, and bits 7..5 read as 0.
- R11: A register write takes effect for the very next access. A data read at 0x0100 or 0x0101 returns the page or the mapping value on `reg_rdata` in the next cycle. Other reads return 0.
- R12: When `code_rd` is high, the access is a code fetch, even if a data strobe is high as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| code_rd | input | 1 | Code-fetch strobe |
| data_rd | input | 1 | Data read strobe |
| data_wr | input | 1 | Data write strobe |
| wdata | input | 8 | Write data, used for register writes |
| fs_sel | output | 8 | Main-flash sector selects, one-hot or zero |
| boot_sel | output | 4 | Boot-flash sector selects |
| sram_sel | output | 1 | SRAM select |
| iop_sel | output | 1 | I/O block select |
| mem_we | output | 1 | Write strobe for writable memories |
| reg_rdata | output | 8 | Register read data |
| flash_wr_flag | output | 1 | Sticky flag for a data write aimed at flash |

## Verification
The hardest situations to reach are the overlaps that let priority act. At reset the regions are disjoint, so the stimulus has to program the mapping register first. Setting bit 1 puts the boot flash under the I/O block and the SRAM in data space. Setting bit 3 moves the boot flash over the main-flash window in code space. Directed sequences perform these writes and then probe the borders of each region. A seeded random phase then mixes register writes with every strobe combination, including a code fetch and a data strobe in the same cycle. A reference model in the bench predicts each registered output one cycle later.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  // register offsets inside the I/O block
  localparam int unsigned OFS_PAGE = 0;
  localparam int unsigned OFS_MAP  = 1;
  // mapping register fields
  localparam int unsigned MAP_W         = 5;
  localparam int unsigned MB_MAIN_CODE  = 0;
  localparam int unsigned MB_BOOT_DATA  = 1;
  localparam int unsigned MB_BOOT_OFF   = 2;
  localparam int unsigned MB_BOOT_HIGH  = 3;
  localparam int unsigned MB_MAIN_DATA  = 4;
  localparam int unsigned MB_FLAG_CLR   = 7;
endpackage

// File: rtl/pwd_regs.sv
module pwd_regs #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     io_wr,
  input  logic [7:0]               io_ofs,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     flash_wr,
  output logic [PAGE_W-1:0]        page,
  output logic [pwd_pkg::MAP_W-1:0] map,
  output logic                     flag
);
  import pwd_pkg::*;

  logic page_we, map_we, clr;
  logic unused_wdata;

  assign page_we = io_wr && (io_ofs == 8'(OFS_PAGE));
  assign map_we  = io_wr && (io_ofs == 8'(OFS_MAP));
  assign clr     = map_we && wdata[MB_FLAG_CLR];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      page <= '0;
      map  <= '0;
      flag <= 1'b0;
    end else begin
      if (page_we) page <= wdata[PAGE_W-1:0];
      if (map_we)  map  <= wdata[MAP_W-1:0];
      if (clr)           flag <= 1'b0;
      else if (flash_wr) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/pwd_space_decode.sv
module pwd_space_decode #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAIN_SECTORS = 8,
  parameter int unsigned BOOT_SECTORS = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0100,
  parameter logic [ADDR_W-1:0] SRAM_LO = 16'h0200,
  parameter logic [ADDR_W-1:0] SRAM_HI = 16'h7FFF,
  localparam int unsigned PAGE_W = $clog2(MAIN_SECTORS),
  localparam int unsigned BOOT_W = $clog2(BOOT_SECTORS)
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      code_rd,
  input  logic                      data_rd,
  input  logic                      data_wr,
  input  logic [PAGE_W-1:0]         page,
  input  logic [pwd_pkg::MAP_W-1:0] map,
  output logic [MAIN_SECTORS-1:0]   fs_hit,
  output logic [BOOT_SECTORS-1:0]   boot_hit,
  output logic                      sram_hit,
  output logic                      iop_hit,
  output logic                      we,
  output logic                      flash_wr,
  output logic                      io_wr,
  output logic [DATA_W-1:0]         rd_data
);
  import pwd_pkg::*;

  localparam int unsigned IO_SPAN_W = 8;

  logic in_code, in_data, upper;
  logic boot_en, boot_any, main_en, main_any;
  logic [BOOT_W-1:0] boot_idx;

  assign in_code = code_rd;
  assign in_data = !code_rd && (data_rd || data_wr);
  assign upper   = addr[ADDR_W-1];

  // priority: I/O, then SRAM, then boot flash, then main flash
  assign iop_hit  = in_data && (addr[ADDR_W-1:IO_SPAN_W] == IO_BASE[ADDR_W-1:IO_SPAN_W]);
  assign sram_hit = in_data && (addr >= SRAM_LO) && (addr <= SRAM_HI) && !iop_hit;

  assign boot_en  = in_code ? !map[MB_BOOT_OFF] : (in_data && map[MB_BOOT_DATA]);
  assign boot_any = boot_en && (upper == map[MB_BOOT_HIGH]) && !iop_hit && !sram_hit;
  assign boot_idx = addr[ADDR_W-2 -: BOOT_W];

  assign main_en  = in_code ? map[MB_MAIN_CODE] : (in_data && map[MB_MAIN_DATA]);
  assign main_any = main_en && upper && !boot_any && !sram_hit && !iop_hit;

  for (genvar b = 0; b < BOOT_SECTORS; b++) begin : g_boot
    localparam logic [BOOT_W-1:0] BIDX = BOOT_W'(b);
    assign boot_hit[b] = boot_any && (boot_idx == BIDX);
  end

  for (genvar s = 0; s < MAIN_SECTORS; s++) begin : g_main
    localparam logic [PAGE_W-1:0] SIDX = PAGE_W'(s);
    assign fs_hit[s] = main_any && (page == SIDX);
  end

  assign we       = data_wr && !code_rd && (sram_hit || iop_hit);
  assign flash_wr = data_wr && !code_rd && (main_any || boot_any);
  assign io_wr    = data_wr && iop_hit;

  always_comb begin
    rd_data = '0;
    if (iop_hit && data_rd) begin
      if (addr[IO_SPAN_W-1:0] == IO_SPAN_W'(OFS_PAGE))     rd_data = DATA_W'(page);
      else if (addr[IO_SPAN_W-1:0] == IO_SPAN_W'(OFS_MAP)) rd_data = DATA_W'(map);
    end
  end
endmodule

// File: rtl/pwd_decoder.sv
module pwd_decoder #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAIN_SECTORS = 8,
  parameter int unsigned BOOT_SECTORS = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0100,
  parameter logic [ADDR_W-1:0] SRAM_LO = 16'h0200,
  parameter logic [ADDR_W-1:0] SRAM_HI = 16'h7FFF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    code_rd,
  input  logic                    data_rd,
  input  logic                    data_wr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [MAIN_SECTORS-1:0] fs_sel,
  output logic [BOOT_SECTORS-1:0] boot_sel,
  output logic                    sram_sel,
  output logic                    iop_sel,
  output logic                    mem_we,
  output logic [DATA_W-1:0]       reg_rdata,
  output logic                    flash_wr_flag
);
  import pwd_pkg::*;

  localparam int unsigned PAGE_W = $clog2(MAIN_SECTORS);

  logic [PAGE_W-1:0]       page;
  logic [MAP_W-1:0]        map;
  logic [MAIN_SECTORS-1:0] fs_hit;
  logic [BOOT_SECTORS-1:0] boot_hit;
  logic                    sram_hit, iop_hit, we, flash_wr, io_wr;
  logic [DATA_W-1:0]       rd_data;

  pwd_space_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MAIN_SECTORS(MAIN_SECTORS), .BOOT_SECTORS(BOOT_SECTORS),
    .IO_BASE(IO_BASE), .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI)
  ) u_dec (
    .addr(addr), .code_rd(code_rd), .data_rd(data_rd), .data_wr(data_wr),
    .page(page), .map(map),
    .fs_hit(fs_hit), .boot_hit(boot_hit), .sram_hit(sram_hit), .iop_hit(iop_hit),
    .we(we), .flash_wr(flash_wr), .io_wr(io_wr), .rd_data(rd_data)
  );

  pwd_regs #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_ofs(addr[7:0]), .wdata(wdata),
    .flash_wr(flash_wr), .page(page), .map(map), .flag(flash_wr_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_sel    <= '0;
      boot_sel  <= '0;
      sram_sel  <= 1'b0;
      iop_sel   <= 1'b0;
      mem_we    <= 1'b0;
      reg_rdata <= '0;
    end else begin
      fs_sel    <= fs_hit;
      boot_sel  <= boot_hit;
      sram_sel  <= sram_hit;
      iop_sel   <= iop_hit;
      mem_we    <= we;
      reg_rdata <= rd_data;
    end
  end
endmodule

// File: rtl/pwd_decoder_chk.sv
module pwd_decoder_chk #(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned MAIN_SECTORS = 8,
  parameter int unsigned BOOT_SECTORS = 4,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'h0100
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       addr,
  input logic                    code_rd,
  input logic                    data_rd,
  input logic                    data_wr,
  input logic [DATA_W-1:0]       wdata,
  input logic [MAIN_SECTORS-1:0] fs_sel,
  input logic [BOOT_SECTORS-1:0] boot_sel,
  input logic                    sram_sel,
  input logic                    iop_sel,
  input logic                    mem_we,
  input logic [DATA_W-1:0]       reg_rdata,
  input logic                    flash_wr_flag
);
  localparam logic [ADDR_W-1:0] MAP_ADDR = IO_BASE + ADDR_W'(1);

  AST_SINGLE_SELECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fs_sel, boot_sel, sram_sel, iop_sel})); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(code_rd || data_rd || data_wr) |=> (fs_sel == '0 && boot_sel == '0 && !sram_sel && !iop_sel && !mem_we && reg_rdata == '0)); // R2

  AST_CODE_SKIPS_DATA_MEM: assert property (@(posedge clk) disable iff (rst)
    code_rd |=> (!sram_sel && !iop_sel && !mem_we)); // R6

  AST_NO_FLASH_WE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (fs_sel == '0 && boot_sel == '0)); // R9

  AST_FLAG_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(flash_wr_flag) |-> $past(data_wr && !code_rd && addr == MAP_ADDR && wdata[7])); // R10

  AST_FLAG_SET_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flash_wr_flag) |-> $past(data_wr && !code_rd)); // R10
endmodule

bind pwd_decoder pwd_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MAIN_SECTORS(MAIN_SECTORS), .BOOT_SECTORS(BOOT_SECTORS), .IO_BASE(IO_BASE)
) u_chk (.*);

// File: tb/tb_pwd_decoder.sv
module tb_pwd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst;
  logic [15:0] addr;
  logic code_rd, data_rd, data_wr;
  logic [7:0] wdata;
  logic [7:0] fs_sel;
  logic [3:0] boot_sel;
  logic sram_sel, iop_sel, mem_we, flash_wr_flag;
  logic [7:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [2:0] m_page;
  logic [4:0] m_map;
  logic       m_flag;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwd_decoder dut (
    .clk(clk), .rst(rst), .addr(addr), .code_rd(code_rd), .data_rd(data_rd),
    .data_wr(data_wr), .wdata(wdata), .fs_sel(fs_sel), .boot_sel(boot_sel),
    .sram_sel(sram_sel), .iop_sel(iop_sel), .mem_we(mem_we),
    .reg_rdata(reg_rdata), .flash_wr_flag(flash_wr_flag)
  );

  // expected {fs, boot, sram, iop, we, rdata}
  function automatic logic [22:0] expect_out(input logic [15:0] a, input logic cr, dr, dw,
                                             input logic [2:0] pg, input logic [4:0] mp);
    logic code, data, iop, sram, ben, bhit, men, mhit, we;
    logic [3:0] boot;
    logic [7:0] fs, rd;
    code = cr;
    data = !cr && (dr || dw);
    iop  = data && (a[15:8] == 8'h01);
    sram = data && (a >= 16'h0200) && (a <= 16'h7FFF) && !iop;
    ben  = code ? !mp[2] : (data && mp[1]);
    bhit = ben && (a[15] == mp[3]) && !iop && !sram;
    boot = bhit ? (4'b0001 << a[14:13]) : 4'b0;
    men  = code ? mp[0] : (data && mp[4]);
    mhit = men && a[15] && !bhit && !sram && !iop;
    fs   = mhit ? (8'b1 << pg) : 8'b0;
    we   = dw && !cr && (sram || iop);
    rd   = 8'h00;
    if (iop && dr) begin
      if (a[7:0] == 8'h00) rd = {5'b0, pg};
      else if (a[7:0] == 8'h01) rd = {3'b0, mp};
    end
    return {fs, boot, sram, iop, we, rd};
  endfunction

  task automatic access(input logic [15:0] a, input logic cr, dr, dw,
                        input logic [7:0] wd, input string tag);
    logic [22:0] exp_v, got_v;
    logic exp_flag;
    addr = a; code_rd = cr; data_rd = dr; data_wr = dw; wdata = wd;
    exp_v = expect_out(a, cr, dr, dw, m_page, m_map);
    exp_flag = m_flag;
    if (dw && !cr && a[15:8] == 8'h01) begin
      if (a[7:0] == 8'h00) m_page = wd[2:0];
      if (a[7:0] == 8'h01) begin
        m_map = wd[4:0];
        if (wd[7]) exp_flag = 1'b0;
      end
    end
    if (dw && !cr && (exp_v[22:11] != 12'h0)) exp_flag = 1'b1;
    m_flag = exp_flag;
    @(posedge clk);
    #1;
    got_v = {fs_sel, boot_sel, sram_sel, iop_sel, mem_we, reg_rdata};
    checks++;
    if (got_v !== exp_v || flash_wr_flag !== exp_flag) begin
      errors++;
      $display("FAIL %s addr=%h cr=%b dr=%b dw=%b: got %h flag %b, expected %h flag %b",
               tag, a, cr, dr, dw, got_v, flash_wr_flag, exp_v, exp_flag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_page = 3'd0; m_map = 5'd0; m_flag = 1'b0;
    rst = 1'b1; addr = '0; code_rd = 0; data_rd = 0; data_wr = 0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({fs_sel, boot_sel, sram_sel, iop_sel, mem_we, reg_rdata, flash_wr_flag} !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs: got %h, expected 0",
               {fs_sel, boot_sel, sram_sel, iop_sel, mem_we, reg_rdata, flash_wr_flag});
    end
    rst = 1'b0;
    access(16'h0100, 0, 1, 0, 8'h00, "R1 page reads 0");
    access(16'h0101, 0, 1, 0, 8'h00, "R1 map reads 0");
    access(16'h8000, 1, 0, 0, 8'h00, "R1 main flash off in code");
    // boot sectors
    access(16'h0000, 1, 0, 0, 8'h00, "R5 boot0");
    access(16'h2000, 1, 0, 0, 8'h00, "R5 boot1");
    access(16'h5FFF, 1, 0, 0, 8'h00, "R5 boot2");
    access(16'h7FFF, 1, 0, 0, 8'h00, "R5 boot3");
    access(16'h0000, 0, 0, 0, 8'h00, "R2 idle");
    // main flash in code space, page switch
    access(16'h0101, 0, 0, 1, 8'h01, "R11 map write");
    access(16'h8000, 1, 0, 0, 8'h00, "R3 sector0 code");
    access(16'h0100, 0, 0, 1, 8'h05, "R11 page write");
    access(16'hFFFF, 1, 0, 0, 8'h00, "R3 sector5 code next access");
    access(16'h0100, 0, 1, 0, 8'h00, "R11 page readback");
    access(16'h9000, 0, 1, 0, 8'h00, "R4 data off");
    access(16'h0101, 0, 0, 1, 8'h11, "R11 map write");
    access(16'h9000, 0, 1, 0, 8'h00, "R4 sector5 data");
    // SRAM and I/O
    access(16'h0200, 0, 1, 0, 8'h00, "R6 sram low edge");
    access(16'h7FFF, 0, 1, 0, 8'h00, "R6 sram high edge");
    access(16'h01FF, 0, 1, 0, 8'h00, "R6 io top");
    access(16'h0200, 1, 0, 0, 8'h00, "R6 sram not in code");
    access(16'h0000, 0, 1, 0, 8'h00, "R8 data low empty");
    access(16'h00FF, 0, 0, 1, 8'h00, "R8 data low empty write");
    // write strobe and flag
    access(16'h0300, 0, 0, 1, 8'hAA, "R9 sram write strobe");
    access(16'h8000, 0, 0, 1, 8'h55, "R9 flash write no strobe");
    access(16'h0200, 0, 1, 0, 8'h00, "R10 flag sticky");
    access(16'h0101, 0, 0, 1, 8'hF1, "R10 flag clear");
    access(16'h0101, 0, 1, 0, 8'h00, "R10 map bits 7..5 read 0");
    // overlaps
    access(16'h0101, 0, 0, 1, 8'h02, "R7 boot into data");
    access(16'h0050, 0, 1, 0, 8'h00, "R7 boot in data low");
    access(16'h0150, 0, 1, 0, 8'h00, "R7 io over boot");
    access(16'h0250, 0, 1, 0, 8'h00, "R7 sram over boot");
    access(16'h0060, 0, 0, 1, 8'h00, "R10 boot write flags");
    access(16'h0101, 0, 0, 1, 8'h89, "R7 boot high with main code");
    access(16'h8000, 1, 0, 0, 8'h00, "R7 boot over main flash");
    access(16'hE000, 1, 0, 0, 8'h00, "R7 boot3 over main flash");
    access(16'h0000, 1, 0, 0, 8'h00, "R5 boot moved away");
    access(16'h0101, 0, 0, 1, 8'h05, "R5 boot off");
    access(16'h0000, 1, 0, 0, 8'h00, "R5 boot off code");
    access(16'hC000, 1, 0, 0, 8'h00, "R5 main visible with boot off");
    access(16'h0101, 0, 0, 1, 8'h00, "R12 map reset");
    access(16'h0300, 1, 0, 1, 8'h00, "R12 code wins over data write");
    access(16'h0101, 1, 0, 1, 8'h1F, "R12 no reg write in code");
    access(16'h0101, 0, 1, 0, 8'h00, "R12 map unchanged");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [2:0] kind;
      logic [7:0] wd;
      a = 16'($urandom);
      kind = 3'($urandom % 6);
      wd = 8'($urandom);
      case ($urandom % 4)
        0: a = {8'h01, 7'h0, a[0]};
        1: a = {8'h00, a[7:0]};
        default: ;
      endcase
      case (kind)
        0: access(a, 0, 0, 0, wd, "R2 random idle");
        1: access(a, 1, 0, 0, wd, "R7 random code");
        2: access(a, 0, 1, 0, wd, "R7 random data read");
        3: access(a, 0, 0, 1, wd, "R9 random data write");
        4: access(a, 1, 1, 1, wd, "R12 random mixed");
        default: access({8'h01, 7'h0, a[0]}, 0, 0, 1, wd, "R11 random reg write");
      endcase
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule